// File: doc/BRIEF.md
# Priority-Arbitrated Atomic Reservation Monitor

This block keeps one hardware thread's reservation for a load-linked / store-conditional pair. A reservation covers a whole cache line. When a load-linked arrives, the block stores the line tag and the thread's priority. If the line is not already held exclusive, the block asks for ownership. While the request is outstanding, the fetch request output stays high. If the owner refuses to grant exclusivity, the load-linked still completes normally. The refusal is only remembered, and it shows up later as a failing store-conditional.

Other agents send coherence probes, and each probe carries the requester's priority. A probe that lands in a live reserved line is resolved by comparing priorities. If the requester is strictly more important, the line is granted and the local atomic is doomed. Otherwise the probe is refused and the requester's atomic fails instead. A sticky contention flag tells software that contention happened, so it can back off. The store-conditional gets its pass or fail result one cycle after it is issued. Every store-conditional ends the reservation.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked with `llHitExcl`=1 arms the reservation and leaves `fetchReq` low.
- R2: A load-linked with `llHitExcl`=0 raises `fetchReq` from the next cycle until `fetchDone` is seen. `fetchAddr` carries the load address with its low `LINE_OFF_W` bits zero.
- R3: If `fetchDone` arrives with `fetchGranted`=0, no error is signalled. The reservation is marked failed, and the next store-conditional reports fail.
- R4: `scValid` pulses exactly one cycle after `scReq`. `scPass`=1 only if the reservation is armed, not failed, has no fetch outstanding, and the store address lies in the reserved line. Any store-conditional drops the reservation, and a failing one performs no write (`scPass`=0).
- R5: Line matching ignores the low `LINE_OFF_W` address bits for both probes and store-conditionals.
- R6: A probe into the live reserved line with a priority strictly above the holder's is granted (`probeGrant`=1). The reservation becomes failed.
- R7: A probe into the live reserved line with a priority equal to or below the holder's is refused (`probeGrant`=0). The reservation survives.
- R8: A probe to another line, or made while no live reservation exists, is granted. Every probe gets `probeRespValid` one cycle later.
- R9: `contention` goes high the cycle after any probe conflicts with a live reservation, whether the probe won or lost. It stays high until the next load-linked.
- R10: `clearReq` drops the reservation and any outstanding fetch.
- R11: A new load-linked replaces the old reservation, so a store-conditional to the earlier line fails.
- R12: After reset there is no reservation, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llReq | input | 1 | Load-linked strobe |
| llAddr | input | ADDR_W | Load-linked byte address |
| llPrio | input | PRIO_W | Priority of the local thread |
| llHitExcl | input | 1 | Line already held exclusive |
| fetchReq | output | 1 | Fetch-for-ownership outstanding |
| fetchAddr | output | ADDR_W | Line-aligned fetch address |
| fetchDone | input | 1 | Fetch reply strobe |
| fetchGranted | input | 1 | Reply gave exclusive ownership |
| scReq | input | 1 | Store-conditional strobe |
| scAddr | input | ADDR_W | Store-conditional byte address |
| scValid | output | 1 | Store-conditional result valid |
| scPass | output | 1 | Store-conditional succeeded (write allowed) |
| probeValid | input | 1 | Incoming coherence probe |
| probeAddr | input | ADDR_W | Probe byte address |
| probePrio | input | PRIO_W | Requester priority |
| probeRespValid | output | 1 | Probe response valid |
| probeGrant | output | 1 | 1 grant ownership, 0 refuse |
| clearReq | input | 1 | Drop the reservation (context switch, exception) |
| contention | output | 1 | Sticky conflict flag |

## Verification
A corrupt reserved tag or a wrong priority register shows up at the probe after the load-linked. The probe response, one cycle later, grants when it should refuse, or the reverse. A lost failed or pending bit stays hidden until the next store-conditional, and then `scPass` is wrong one cycle after `scReq`. The bench therefore pairs every probe with a following store-conditional. It sweeps every holder and requester priority pair, so errors in the tie and ordering logic are exposed within three cycles of the probe.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef struct packed {
    logic capture;   // load tag and priority from the load-linked
    logic dropTag;   // forget the stored tag (clear)
  } resvStrobe_t;
endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_OFF_W = 4,
  parameter int PRIO_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [PRIO_W-1:0] llPrio,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic [PRIO_W-1:0] probePrio,
  input  logic [ADDR_W-1:0] scAddr,
  output logic              probeHit,
  output logic              probeWins,
  output logic              scHit,
  output logic [ADDR_W-1:0] fetchAddr
);
  localparam int TAG_W = ADDR_W - LINE_OFF_W;

  logic [TAG_W-1:0]  holdTag;
  logic [PRIO_W-1:0] holdPrio;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.dropTag) begin
      holdTag  <= '0;
      holdPrio <= '0;
    end else if (strobe.capture) begin
      holdTag  <= llAddr[ADDR_W-1:LINE_OFF_W];
      holdPrio <= llPrio;
    end
  end

  // Line-granular compares: offset bits never take part
  assign probeHit  = (probeAddr[ADDR_W-1:LINE_OFF_W] == holdTag);
  assign scHit     = (scAddr[ADDR_W-1:LINE_OFF_W] == holdTag);
  // Ties go to the holder
  assign probeWins = (probePrio > holdPrio);

  generate
    if (LINE_OFF_W > 0) begin : g_offset
      assign fetchAddr = {holdTag, {LINE_OFF_W{1'b0}}};
    end else begin : g_nooffset
      assign fetchAddr = holdTag;
    end
  endgenerate
endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        llReq,
  input  logic        llHitExcl,
  input  logic        fetchDone,
  input  logic        fetchGranted,
  input  logic        scReq,
  input  logic        probeValid,
  input  logic        clearReq,
  input  logic        probeHit,
  input  logic        probeWins,
  input  logic        scHit,
  output resvStrobe_t strobe,
  output logic        fetchReq,
  output logic        scValid,
  output logic        scPass,
  output logic        probeRespValid,
  output logic        probeGrant,
  output logic        contention
);
  logic armed, failed, pending;
  logic live, conflict, loseLine;

  assign live     = armed && !failed;
  assign conflict = probeValid && live && probeHit;
  assign loseLine = conflict && probeWins;

  assign strobe.capture = llReq && !clearReq;
  assign strobe.dropTag = clearReq;
  assign fetchReq       = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scValid        <= 1'b0;
      scPass         <= 1'b0;
      probeRespValid <= 1'b0;
      probeGrant     <= 1'b0;
      contention     <= 1'b0;
    end else begin
      scValid        <= scReq;
      scPass         <= scReq && live && !pending && scHit;
      probeRespValid <= probeValid;
      probeGrant     <= probeValid && (!conflict || probeWins);
      if (conflict)   contention <= 1'b1;
      else if (llReq) contention <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clearReq) begin
      armed   <= 1'b0;
      failed  <= 1'b0;
      pending <= 1'b0;
    end else if (llReq) begin
      armed   <= 1'b1;
      failed  <= 1'b0;
      pending <= !llHitExcl;
    end else if (scReq) begin
      armed   <= 1'b0;
      failed  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (pending && fetchDone) begin
        pending <= 1'b0;
        if (!fetchGranted) failed <= 1'b1;
      end
      if (loseLine) failed <= 1'b1;
    end
  end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_OFF_W = 4,
  parameter int PRIO_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              llReq,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [PRIO_W-1:0] llPrio,
  input  logic              llHitExcl,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchDone,
  input  logic              fetchGranted,
  input  logic              scReq,
  input  logic [ADDR_W-1:0] scAddr,
  output logic              scValid,
  output logic              scPass,
  input  logic              probeValid,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic [PRIO_W-1:0] probePrio,
  output logic              probeRespValid,
  output logic              probeGrant,
  input  logic              clearReq,
  output logic              contention
);
  resvStrobe_t strobe;
  logic probeHit, probeWins, scHit;

  resv_datapath #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .PRIO_W(PRIO_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .llAddr(llAddr), .llPrio(llPrio),
    .probeAddr(probeAddr), .probePrio(probePrio), .scAddr(scAddr),
    .probeHit(probeHit), .probeWins(probeWins), .scHit(scHit),
    .fetchAddr(fetchAddr)
  );

  resv_control u_ctl (
    .clk(clk), .rst_n(rst_n),
    .llReq(llReq), .llHitExcl(llHitExcl),
    .fetchDone(fetchDone), .fetchGranted(fetchGranted),
    .scReq(scReq), .probeValid(probeValid), .clearReq(clearReq),
    .probeHit(probeHit), .probeWins(probeWins), .scHit(scHit),
    .strobe(strobe), .fetchReq(fetchReq),
    .scValid(scValid), .scPass(scPass),
    .probeRespValid(probeRespValid), .probeGrant(probeGrant),
    .contention(contention)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic llReq,
  input logic llHitExcl,
  input logic fetchReq,
  input logic scReq,
  input logic scValid,
  input logic scPass,
  input logic probeValid,
  input logic probeRespValid,
  input logic probeGrant,
  input logic clearReq,
  input logic contention
);
  // R4
  sc_result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scReq |=> scValid);
  // R4
  sc_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scReq |=> !scValid);
  // R4
  pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scPass |-> scValid);
  // R8
  probe_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probeValid |=> probeRespValid);
  // R7
  refuse_flags_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probeRespValid && !probeGrant) |-> contention);
  // R2
  fetch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (llReq && !llHitExcl && !clearReq) |=> fetchReq);
  // R1
  no_fetch_on_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (llReq && llHitExcl) |=> !fetchReq);
  // R10
  clear_drops_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> !fetchReq);
endmodule

bind llsc_resv_monitor resv_monitor_chk u_chk (.*);

// File: tb/sim_llsc_resv_monitor.sv
module sim_llsc_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int OW = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic llReq = 0, llHitExcl = 0, fetchDone = 0, fetchGranted = 0;
  logic scReq = 0, probeValid = 0, clearReq = 0;
  logic [AW-1:0] llAddr = '0, scAddr = '0, probeAddr = '0;
  logic [PW-1:0] llPrio = '0, probePrio = '0;
  logic fetchReq, scValid, scPass, probeRespValid, probeGrant, contention;
  logic [AW-1:0] fetchAddr;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_monitor #(.ADDR_W(AW), .LINE_OFF_W(OW), .PRIO_W(PW)) u0 (.*);

  task automatic check(input int act, input int exp, input string msg);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic llOp(input logic [AW-1:0] a, input logic [PW-1:0] p, input bit ex);
    @(negedge clk);
    llReq = 1; llAddr = a; llPrio = p; llHitExcl = ex;
    @(negedge clk);
    llReq = 0; llHitExcl = 0;
  endtask

  task automatic scOp(input logic [AW-1:0] a, input bit expPass, input string msg);
    @(negedge clk);
    scReq = 1; scAddr = a;
    @(negedge clk);
    scReq = 0;
    check(scValid, 1, {msg, " scValid"});
    check(scPass, expPass, {msg, " scPass"});
  endtask

  task automatic probeOp(input logic [AW-1:0] a, input logic [PW-1:0] p,
                         input bit expGrant, input string msg);
    @(negedge clk);
    probeValid = 1; probeAddr = a; probePrio = p;
    @(negedge clk);
    probeValid = 0;
    check(probeRespValid, 1, {msg, " respValid"});
    check(probeGrant, expGrant, {msg, " grant"});
  endtask

  task automatic fetchOp(input bit g);
    @(negedge clk);
    fetchDone = 1; fetchGranted = g;
    @(negedge clk);
    fetchDone = 0; fetchGranted = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R12 reset state
    check(fetchReq, 0, "R12 fetchReq");
    check(scValid | scPass, 0, "R12 sc outputs");
    check(probeRespValid | probeGrant, 0, "R12 probe outputs");
    check(contention, 0, "R12 contention");
    rst_n = 1;
    scOp(16'h1230, 0, "R12 sc without reservation");

    // R1 exclusive hit, no fetch; then pass
    llOp(16'h4A37, 3, 1);
    check(fetchReq, 0, "R1 no fetch");
    scOp(16'h4A3C, 1, "R1/R5 sc same line other offset");
    scOp(16'h4A3C, 0, "R4 reservation dropped by sc");

    // R2 fetch granted
    llOp(16'h77E5, 2, 0);
    check(fetchReq, 1, "R2 fetchReq");
    check(fetchAddr, 16'h77E0, "R2 fetchAddr");
    scOp(16'h77E5, 0, "R4 sc while fetch outstanding");
    llOp(16'h77E5, 2, 0);
    fetchOp(1);
    check(fetchReq, 0, "R2 fetchReq cleared");
    scOp(16'h77E9, 1, "R2 sc after granted fetch");

    // R3 fetch denied
    llOp(16'h5550, 4, 0);
    fetchOp(0);
    check(fetchReq, 0, "R3 fetch closed");
    scOp(16'h5550, 0, "R3 sc after denied fetch");

    // R4 sc to other line
    llOp(16'h2000, 1, 1);
    scOp(16'h2010, 0, "R4 sc other line");

    // R6/R7/R9 priority sweep
    for (int h = 0; h < 8; h++) begin
      for (int p = 0; p < 8; p++) begin
        logic [AW-1:0] base;
        bit win;
        base = AW'((h * 8 + p) << OW) + 16'h8000;
        win  = (p > h);
        llOp(base + 16'd3, PW'(h), 1);
        check(contention, 0, "R9 cleared by ll");
        probeOp(base + 16'd12, PW'(p), win, win ? "R6 probe wins" : "R7 probe refused");
        check(contention, 1, "R9 contention set");
        scOp(base, !win, win ? "R6 holder fails" : "R7 holder keeps");
        check(contention, 1, "R9 contention sticky");
      end
    end

    // R8 non-conflicting probes
    llOp(16'h3300, 0, 1);
    probeOp(16'h3310, 7, 1, "R8 other line granted");
    check(contention, 0, "R8/R9 no contention other line");
    probeOp(16'h3305, 7, 1, "R6 winner granted");
    probeOp(16'h3305, 0, 1, "R8 no live reservation granted");
    scOp(16'h3300, 0, "R6 failed reservation");

    // R10 clear
    llOp(16'h6600, 5, 1);
    @(negedge clk); clearReq = 1;
    @(negedge clk); clearReq = 0;
    probeOp(16'h6600, 0, 1, "R10 probe after clear granted");
    scOp(16'h6600, 0, "R10 sc after clear");
    llOp(16'h6600, 5, 0);
    @(negedge clk); clearReq = 1;
    @(negedge clk); clearReq = 0;
    check(fetchReq, 0, "R10 fetch dropped");

    // R11 replacement
    llOp(16'h1100, 2, 1);
    llOp(16'h2200, 2, 1);
    scOp(16'h1100, 0, "R11 old line fails");
    llOp(16'h1100, 2, 1);
    llOp(16'h2200, 2, 1);
    scOp(16'h2204, 1, "R11 new line passes");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule